// File: doc/BRIEF.md
# Disk Sector Address Translator

This block turns the address fields of a disk task file into a linear byte offset on the medium. It reads the sector number, the two cylinder bytes and the drive/head byte, and works in one of two modes. In linear mode the address bytes are joined into a 28-bit block number. In geometric mode the block number comes from the cylinder, the head and the sector, using the head count and the sectors-per-track of the selected drive. Either way, the block number is then scaled by that drive's sector size.

A one-cycle `start` pulse, given while `busy` is low, latches the task-file bytes. The drive bit goes out at once on `drive_sel`, so the surrounding logic can put the matching drive geometry on the `geo_*` inputs. The geometry is sampled in the cycle after the accepted start. A single sequential shift-add multiplier does all the products, one after another. Its loop ends as soon as the remaining multiplier bits are zero. When the result is ready, `done` pulses for one cycle. `geo_err` goes high in the same cycle if geometric addressing was refused.

Top module: `secaddr_xlate`

## Requirements
- R1: `drive_sel` equals bit 4 of the drive/head byte captured by the last accepted start. It changes only in the cycle after an accepted start.
- R2: With bit 6 of drive/head set (linear mode), the block number is {drive/head[3:0], cylinder high, cylinder low, sector}, placed in bits 27:24, 23:16, 15:8 and 7:0. `byte_off` is that block number times the sector size.
- R3: With bit 6 clear (geometric mode), the block number is ({cylinder high, cylinder low} × head count + drive/head[3:0]) × sectors-per-track + sector − 1. `byte_off` is that block number times the sector size.
- R4: A `geo_bytes` value of zero is treated as a sector size of 512.
- R5: In geometric mode, a head count of zero or a sectors-per-track of zero ends the operation with `done` and `geo_err` both high and `byte_off` set to zero.
- R6: In geometric mode, a sector number of zero is refused in the same way as R5.
- R7: `start` is accepted only while `busy` is low. `busy` is high from the cycle after acceptance until the result arrives. `done` lasts exactly one cycle, and `busy` is low during it. `geo_err` is never high without `done`.
- R8: A `start` pulse while `busy` is high is ignored. Task-file inputs that change after acceptance have no effect on the result or on `drive_sel`.
- R9: Linear mode never raises `geo_err`, whatever the geometry inputs hold.
- R10: While reset is high and after it is released, `busy`, `done`, `geo_err` and `drive_sel` are low and `byte_off` is zero.
- R11: `byte_off` holds its value except in a cycle where `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a translation (taken only when not busy) |
| sect_num | input | 8 | Task-file sector number |
| cyl_lo | input | 8 | Task-file cylinder low byte |
| cyl_hi | input | 8 | Task-file cylinder high byte |
| drv_head | input | 8 | Task-file drive/head byte (bit 6 mode, bit 4 drive, bits 3:0 head or top block bits) |
| geo_heads | input | HEAD_W | Head count of the selected drive |
| geo_spt | input | SPT_W | Sectors per track of the selected drive |
| geo_bytes | input | SSZ_W | Sector size in bytes of the selected drive (0 means 512) |
| drive_sel | output | 1 | Latched drive select bit |
| busy | output | 1 | Translation in progress |
| done | output | 1 | One-cycle completion pulse |
| geo_err | output | 1 | Geometric addressing refused (valid with done) |
| byte_off | output | 28+SSZ_W | Resulting byte offset |

## Verification
The assertions assume that reset is high at the first clock edge and that `start` stays low while reset is high. They also assume that the geometry inputs describe the drive shown on `drive_sel` in the cycle after an accepted start. The bench drives the geometry together with `start` and keeps it steady until `done`. It also scrambles the task-file bytes right after acceptance and pulses `start` again during some operations, so the assertions see accepted and ignored starts alike. The sweeps hold sector sizes to values whose product fits the offset width, and head counts to the 4-bit field.

// File: rtl/secaddr_pkg.sv
package secaddr_pkg;

  // Width of a block number built from the 8-bit task-file bytes
  localparam int unsigned TF_BLK_W = 28;
  localparam int unsigned TF_CYL_W = 16;
  localparam int unsigned DEF_SECTOR_BYTES = 512;

  typedef struct packed {
    logic [7:0] dh;
    logic [7:0] cyl_hi;
    logic [7:0] cyl_lo;
    logic [7:0] sect;
  } taskfile_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_MUL_CH,
    ST_MUL_CS,
    ST_MUL_SZ
  } xl_state_t;

endpackage

// File: rtl/secaddr_tf_decode.sv
module secaddr_tf_decode
  import secaddr_pkg::*;
#(
  parameter int unsigned HEAD_W = 4,
  parameter int unsigned SPT_W  = 8
) (
  input  taskfile_t              tf,
  input  logic [HEAD_W-1:0]      heads,
  input  logic [SPT_W-1:0]       spt,
  output logic                   drive,
  output logic                   lba,
  output logic [TF_BLK_W-1:0]    lba_blk,
  output logic [TF_CYL_W-1:0]    cyl,
  output logic [3:0]             head,
  output logic [7:0]             sect,
  output logic                   chs_err
);

  logic unused_dh_bits;

  always_comb begin
    drive   = tf.dh[4];
    lba     = tf.dh[6];
    head    = tf.dh[3:0];
    sect    = tf.sect;
    cyl     = {tf.cyl_hi, tf.cyl_lo};
    lba_blk = {tf.dh[3:0], tf.cyl_hi, tf.cyl_lo, tf.sect};
    // geometric mode needs a non-empty geometry and a one-based sector
    chs_err = !tf.dh[6] &&
              ((heads == '0) || (spt == '0) || (tf.sect == 8'd0));
  end

  assign unused_dh_bits = ^{tf.dh[7], tf.dh[5]};

endmodule

// File: rtl/secaddr_shift_mul.sv
module secaddr_shift_mul #(
  parameter int unsigned A_W = 28,
  parameter int unsigned B_W = 13,
  localparam int unsigned P_W = A_W + B_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           go,
  input  logic [A_W-1:0] a,
  input  logic [B_W-1:0] b,
  output logic           done,
  output logic [P_W-1:0] p
);

  logic           run;
  logic [P_W-1:0] acc;
  logic [P_W-1:0] mcand;
  logic [B_W-1:0] mplier;

  always_ff @(posedge clk) begin
    if (rst) begin
      run    <= 1'b0;
      done   <= 1'b0;
      acc    <= '0;
      mcand  <= '0;
      mplier <= '0;
    end else begin
      done <= 1'b0;
      if (go) begin
        run    <= 1'b1;
        acc    <= '0;
        mcand  <= P_W'(a);
        mplier <= b;
      end else if (run) begin
        if (mplier == '0) begin
          // remaining multiplier bits are zero: the sum is final
          run  <= 1'b0;
          done <= 1'b1;
        end else begin
          if (mplier[0]) acc <= acc + mcand;
          mcand  <= mcand << 1;
          mplier <= mplier >> 1;
        end
      end
    end
  end

  assign p = acc;

endmodule

// File: rtl/secaddr_xlate.sv
module secaddr_xlate
  import secaddr_pkg::*;
#(
  parameter int unsigned HEAD_W = 4,
  parameter int unsigned SPT_W  = 8,
  parameter int unsigned SSZ_W  = 13
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        start,
  input  logic [7:0]                  sect_num,
  input  logic [7:0]                  cyl_lo,
  input  logic [7:0]                  cyl_hi,
  input  logic [7:0]                  drv_head,
  input  logic [HEAD_W-1:0]           geo_heads,
  input  logic [SPT_W-1:0]            geo_spt,
  input  logic [SSZ_W-1:0]            geo_bytes,
  output logic                        drive_sel,
  output logic                        busy,
  output logic                        done,
  output logic                        geo_err,
  output logic [TF_BLK_W+SSZ_W-1:0]   byte_off
);

  localparam int unsigned OFF_W = TF_BLK_W + SSZ_W;

  xl_state_t          state;
  taskfile_t          tf_q;
  logic [SPT_W-1:0]   spt_q;
  logic [SSZ_W-1:0]   size_q;
  logic [SSZ_W-1:0]   size_eff;
  logic               done_q;
  logic               err_q;
  logic [OFF_W-1:0]   off_q;

  logic                dec_drive;
  logic                dec_lba;
  logic [TF_BLK_W-1:0] dec_blk;
  logic [TF_CYL_W-1:0] dec_cyl;
  logic [3:0]          dec_head;
  logic [7:0]          dec_sect;
  logic                dec_err;

  logic                mul_go;
  logic [TF_BLK_W-1:0] mul_a;
  logic [SSZ_W-1:0]    mul_b;
  logic                mul_done;
  logic [OFF_W-1:0]    mul_p;

  secaddr_tf_decode #(
    .HEAD_W (HEAD_W),
    .SPT_W  (SPT_W)
  ) u_dec (
    .tf      (tf_q),
    .heads   (geo_heads),
    .spt     (geo_spt),
    .drive   (dec_drive),
    .lba     (dec_lba),
    .lba_blk (dec_blk),
    .cyl     (dec_cyl),
    .head    (dec_head),
    .sect    (dec_sect),
    .chs_err (dec_err)
  );

  secaddr_shift_mul #(
    .A_W (TF_BLK_W),
    .B_W (SSZ_W)
  ) u_mul (
    .clk  (clk),
    .rst  (rst),
    .go   (mul_go),
    .a    (mul_a),
    .b    (mul_b),
    .done (mul_done),
    .p    (mul_p)
  );

  assign size_eff = (geo_bytes == '0) ? SSZ_W'(DEF_SECTOR_BYTES) : geo_bytes;

  // Operand steering: every product goes through the one shared multiplier
  always_comb begin
    mul_go = 1'b0;
    mul_a  = '0;
    mul_b  = '0;
    unique case (state)
      ST_SETUP: begin
        if (!dec_err) begin
          mul_go = 1'b1;
          if (dec_lba) begin
            mul_a = dec_blk;
            mul_b = size_eff;
          end else begin
            mul_a = TF_BLK_W'(dec_cyl);
            mul_b = SSZ_W'(geo_heads);
          end
        end
      end
      ST_MUL_CH: begin
        if (mul_done) begin
          mul_go = 1'b1;
          mul_a  = mul_p[TF_BLK_W-1:0] + TF_BLK_W'(dec_head);
          mul_b  = SSZ_W'(spt_q);
        end
      end
      ST_MUL_CS: begin
        if (mul_done) begin
          mul_go = 1'b1;
          // one-based sector: subtract one after the track term
          mul_a  = mul_p[TF_BLK_W-1:0] + TF_BLK_W'(dec_sect) - TF_BLK_W'(1);
          mul_b  = size_q;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      tf_q   <= '0;
      spt_q  <= '0;
      size_q <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      off_q  <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            tf_q  <= '{dh: drv_head, cyl_hi: cyl_hi, cyl_lo: cyl_lo,
                       sect: sect_num};
            state <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          spt_q  <= geo_spt;
          size_q <= size_eff;
          if (dec_err) begin
            done_q <= 1'b1;
            err_q  <= 1'b1;
            off_q  <= '0;
            state  <= ST_IDLE;
          end else if (dec_lba) begin
            state <= ST_MUL_SZ;
          end else begin
            state <= ST_MUL_CH;
          end
        end
        ST_MUL_CH: if (mul_done) state <= ST_MUL_CS;
        ST_MUL_CS: if (mul_done) state <= ST_MUL_SZ;
        ST_MUL_SZ: begin
          if (mul_done) begin
            off_q  <= mul_p;
            done_q <= 1'b1;
            state  <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign drive_sel = dec_drive;
  assign busy      = (state != ST_IDLE);
  assign done      = done_q;
  assign geo_err   = err_q;
  assign byte_off  = off_q;

endmodule

// File: rtl/secaddr_xlate_chk.sv
module secaddr_xlate_chk #(
  parameter int unsigned OFF_W = 41
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             drive_sel,
  input logic             busy,
  input logic             done,
  input logic             geo_err,
  input logic [OFF_W-1:0] byte_off
);

  // R1: the drive bit moves only after an accepted start
  p_drv_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !$past(start && !busy) |-> $stable(drive_sel));

  // R7: completion is a single-cycle pulse
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7: the unit is idle in the completion cycle
  p_idle_at_done_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R7: an idle start makes the unit busy next cycle
  p_accept_r7: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  // R7: error flag only accompanies completion
  p_err_with_done_r7: assert property (@(posedge clk) disable iff (rst)
    geo_err |-> done);

  // R5: a refused translation reports a zero offset
  p_err_zero_r5: assert property (@(posedge clk) disable iff (rst)
    geo_err |-> (byte_off == '0));

  // R11: offset changes only with completion
  p_off_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(byte_off));

endmodule

bind secaddr_xlate secaddr_xlate_chk #(
  .OFF_W (secaddr_pkg::TF_BLK_W + SSZ_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .drive_sel (drive_sel),
  .busy      (busy),
  .done      (done),
  .geo_err   (geo_err),
  .byte_off  (byte_off)
);

// File: tb/sim_secaddr_xlate.sv
module sim_secaddr_xlate;

  localparam int HW = 4;
  localparam int SW = 8;
  localparam int ZW = 13;
  localparam int OW = 28 + ZW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [7:0]    sect = '0;
  logic [7:0]    clo = '0;
  logic [7:0]    chi = '0;
  logic [7:0]    dh = '0;
  logic [HW-1:0] gh = '0;
  logic [SW-1:0] gs = '0;
  logic [ZW-1:0] gz = '0;
  logic          drive_sel;
  logic          busy;
  logic          done;
  logic          geo_err;
  logic [OW-1:0] byte_off;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  secaddr_xlate #(.HEAD_W(HW), .SPT_W(SW), .SSZ_W(ZW)) u0 (
    .clk (clk), .rst (rst), .start (start),
    .sect_num (sect), .cyl_lo (clo), .cyl_hi (chi), .drv_head (dh),
    .geo_heads (gh), .geo_spt (gs), .geo_bytes (gz),
    .drive_sel (drive_sel), .busy (busy), .done (done),
    .geo_err (geo_err), .byte_off (byte_off)
  );

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic run(logic [7:0] d, logic [7:0] hi, logic [7:0] lo,
                     logic [7:0] s, logic [HW-1:0] h, logic [SW-1:0] sp,
                     logic [ZW-1:0] z, bit poke);
    longint blk;
    longint sz;
    longint expo;
    bit     eerr;
    string  rq;
    string  rqe;
    int     n;
    sz = (z == 0) ? 512 : longint'(z);
    if (d[6]) begin
      blk  = longint'({d[3:0], hi, lo, s});
      eerr = 1'b0;
      rq   = "R2";
      rqe  = "R9";
    end else begin
      eerr = (h == 0) || (sp == 0) || (s == 0);
      rqe  = (s == 0 && h != 0 && sp != 0) ? "R6" : "R5";
      blk  = eerr ? 0 : (longint'({hi, lo}) * longint'(h) + longint'(d[3:0]))
                         * longint'(sp) + longint'(s) - 1;
      rq   = "R3";
    end
    if (z == 0) rq = "R4";
    expo = eerr ? 0 : blk * sz;

    @(negedge clk);
    dh = d; chi = hi; clo = lo; sect = s; gh = h; gs = sp; gz = z;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R7", "busy after start", longint'(busy), 1);
    chk("R1", "drive_sel", longint'(drive_sel), longint'(d[4]));
    // R8: task file changes after acceptance must not matter
    dh = ~d; chi = ~hi; clo = lo ^ 8'h5a; sect = s + 8'd3;
    if (poke) begin
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R8", "drive_sel after ignored start", longint'(drive_sel),
          longint'(d[4]));
    end
    n = 0;
    while (done !== 1'b1 && n < 300) begin
      @(negedge clk);
      n++;
    end
    if (n >= 300) begin
      chk("R7", "done timeout", 0, 1);
    end else begin
      chk(rqe, "geo_err", longint'(geo_err), longint'(eerr));
      chk(poke ? "R8" : rq, "byte_off", longint'(byte_off), expo);
      chk("R7", "busy at done", longint'(busy), 0);
      @(negedge clk);
      chk("R7", "done width", longint'(done), 0);
      chk("R11", "offset held", longint'(byte_off), expo);
    end
  endtask

  initial begin
    logic [SW-1:0] spts [5];
    logic [7:0]    secs [4];
    logic [15:0]   cyls [4];
    logic [ZW-1:0] sizes[5];
    spts  = '{8'd0, 8'd1, 8'd3, 8'd63, 8'd255};
    secs  = '{8'd0, 8'd1, 8'd7, 8'd255};
    cyls  = '{16'h0000, 16'h0001, 16'h1234, 16'hFFFF};
    sizes = '{13'd0, 13'd512, 13'd4096, 13'd1, 13'd8191};

    repeat (3) @(negedge clk);
    chk("R10", "busy in reset", longint'(busy), 0);
    chk("R10", "done in reset", longint'(done), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R10", "busy", longint'(busy), 0);
    chk("R10", "done", longint'(done), 0);
    chk("R10", "geo_err", longint'(geo_err), 0);
    chk("R10", "drive_sel", longint'(drive_sel), 0);
    chk("R10", "byte_off", longint'(byte_off), 0);

    // Geometric mode sweep
    for (int h = 0; h < 16; h++)
      for (int j = 0; j < 5; j++)
        for (int k = 0; k < 4; k++)
          for (int c = 0; c < 4; c++) begin
            logic [7:0] d;
            d = {1'b1, 1'b0, 1'b1, 1'((c ^ k) & 1), 4'((h + 3 * k + c) % 16)};
            run(d, cyls[c][15:8], cyls[c][7:0], secs[k], HW'(h), spts[j],
                sizes[(h + j + k + c) % 5], 1'b0);
          end

    // Linear mode sweep, geometry zero on half of the runs (R9)
    for (int n = 0; n < 16; n++)
      for (int z = 0; z < 5; z++)
        for (int p = 0; p < 3; p++) begin
          logic [7:0] d;
          logic [7:0] v;
          d = {1'b1, 1'b1, 1'b1, 1'(n & 1), 4'(n)};
          v = (p == 0) ? 8'h00 : (p == 1) ? 8'hFF : 8'h5C;
          run(d, v, v ^ 8'h12, v ^ 8'h34,
              (n % 2 == 0) ? HW'(0) : HW'(5),
              (n % 2 == 0) ? SW'(0) : SW'(17), sizes[z], 1'b0);
        end

    // Starts during busy, both modes and the refused path (R8)
    run(8'hF3, 8'h12, 8'h34, 8'h56, 4'd0, 8'd0, 13'd512, 1'b1);
    run(8'hA5, 8'h01, 8'h02, 8'd9, 4'd15, 8'd63, 13'd0, 1'b1);
    run(8'hB2, 8'h00, 8'h10, 8'd4, 4'd0, 8'd63, 13'd512, 1'b1);
    run(8'hA0, 8'hFF, 8'hFF, 8'd255, 4'd15, 8'd255, 13'd4096, 1'b1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule